// File: doc/BRIEF.md
# Pipeline Forwarding and Interlock Unit

This is the hazard-control logic for a five-stage in-order pipeline. Its stages, in order, are fetch, decode, execute, memory and writeback. It is purely combinational. Each cycle it looks at three things:

- the source register numbers of the instruction in decode and of the instruction in execute;
- the destination numbers and write enables of the three older instructions in execute, memory and writeback;
- load flags for the producers in execute and memory.

From these it produces four kinds of output:

- operand bypass selects for the ALU inputs;
- bypass selects for an equality comparator that resolves branches in decode;
- a stall, which freezes the PC and the fetch/decode register, and a bubble, which turns the instruction entering execute into a nop;
- a flush, which discards the wrong-path fetch after a taken branch.

The register file writes in writeback and reads in decode. A read of a register written in the same cycle returns the new value, so decode never needs a bypass from writeback. An ALU result is bypassed as soon as it sits in the execute/memory or memory/writeback pipeline register.

A load result arrives one cycle too late for the next instruction. A dependent instruction directly behind a load therefore waits exactly one cycle and then takes the value by bypass.

Branches are compared in decode and follow a predict-not-taken policy. Such a branch waits if its operand is still being computed in execute, or is a load that has not left memory.

Top module: `hazard_unit`

## Requirements
- R1: An execute-stage source that equals a nonzero, write-enabled memory-stage destination selects the memory-stage result, encoded 2'b01 on ex_fwd_a/ex_fwd_b.
- R2: An execute-stage source with no memory-stage match, but equal to a nonzero, write-enabled writeback destination, selects the writeback result, encoded 2'b10; with no match at all the select is the register file, 2'b00.
- R3: When both the memory and the writeback stage match the same source, the memory-stage (younger) result wins (2'b01).
- R4: Register 0, and any producer whose write enable is low, never causes a bypass select, a comparator bypass or a stall.
- R5: A load in execute whose nonzero destination equals either decode source raises stall and bubble together.
- R6: A load in execute whose destination matches neither decode source, or a non-load producer in execute that matches, raises no stall for a non-branch instruction.
- R7: A branch in decode stalls when a source equals the destination of any write-enabled producer in execute, or of a load in memory.
- R8: A decode source equal to the destination of a non-load producer in memory, with no execute match, sets its comparator bypass bit (id_fwd_a/id_fwd_b = 1) without stalling.
- R9: Flush is high exactly when a branch is in decode, the comparator reports taken, and no stall is raised.
- R10: A decode source that matches only the writeback destination leaves its comparator bypass bit at 0 and raises no stall, because the register file returns the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_src_a | input | REG_W | First source register of the decode instruction |
| id_src_b | input | REG_W | Second source register of the decode instruction |
| ex_src_a | input | REG_W | First source register of the execute instruction |
| ex_src_b | input | REG_W | Second source register of the execute instruction |
| ex_dst | input | REG_W | Destination of the execute instruction |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_dst | input | REG_W | Destination of the memory-stage instruction |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| wb_dst | input | REG_W | Destination of the writeback instruction |
| wb_wen | input | 1 | Writeback instruction writes a register |
| id_branch | input | 1 | Decode instruction is a conditional branch |
| id_br_taken | input | 1 | Decode comparator outcome, taken |
| ex_fwd_a | output | 2 | ALU operand A select: 00 regfile, 01 memory stage, 10 writeback |
| ex_fwd_b | output | 2 | ALU operand B select, same encoding |
| id_fwd_a | output | 1 | Comparator operand A takes the memory-stage result |
| id_fwd_b | output | 1 | Comparator operand B takes the memory-stage result |
| stall | output | 1 | Hold PC and fetch/decode register |
| bubble | output | 1 | Replace the instruction entering execute with a nop |
| flush | output | 1 | Discard the instruction in fetch |

## Verification
Several internal faults show at the ports in the same cycle as the inputs that trigger them, because the block holds no state:

- A wrong match between producer and source shows as a wrong select code.
- A dropped register-0 or write-enable qualifier shows as a spurious bypass or stall.
- An inverted priority shows as 2'b10 where 2'b01 is expected.
- A missing stall term lets a load-dependent or branch-dependent instruction proceed. At the ports this shows as stall low and, for branches, as a flush raised too early.

The bench applies directed corner patterns, then random vectors drawn from a small register range so that collisions are frequent. It compares every output after each input change.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  // ALU operand source encodings
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_MEM = 2'b01,
    FWD_WB  = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hzd_src_match.sv
// Compares one source register against a list of producers.
// Register 0 and disabled producers never match.
module hzd_src_match #(
  parameter int REG_W = 5,
  parameter int NPROD = 2
) (
  input  logic [REG_W-1:0]            src,
  input  logic [NPROD-1:0][REG_W-1:0] dst,
  input  logic [NPROD-1:0]            wen,
  output logic [NPROD-1:0]            hit
);
  logic src_live;
  assign src_live = (src != '0);

  for (genvar p = 0; p < NPROD; p++) begin : g_prod
    assign hit[p] = src_live && wen[p] && (dst[p] == src);
  end
endmodule

// File: rtl/hzd_alu_bypass.sv
// Operand selects for the execute-stage sources.
// Producer 0 = memory stage, producer 1 = writeback.
module hzd_alu_bypass import hzd_pkg::*; #(
  parameter int REG_W = 5,
  parameter int NSRC  = 2
) (
  input  logic [NSRC-1:0][REG_W-1:0] src,
  input  logic [REG_W-1:0]           mem_dst,
  input  logic                       mem_wen,
  input  logic [REG_W-1:0]           wb_dst,
  input  logic                       wb_wen,
  output logic [NSRC-1:0][1:0]       sel
);
  localparam int NPROD = 2;

  logic [NPROD-1:0][REG_W-1:0] pdst;
  logic [NPROD-1:0]            pwen;
  assign pdst = {wb_dst, mem_dst};
  assign pwen = {wb_wen, mem_wen};

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic [NPROD-1:0] hit;

    hzd_src_match #(.REG_W(REG_W), .NPROD(NPROD)) u_match (
      .src(src[s]), .dst(pdst), .wen(pwen), .hit(hit)
    );

    always_comb begin
      if (hit[0])      sel[s] = FWD_MEM;   // younger producer first
      else if (hit[1]) sel[s] = FWD_WB;
      else             sel[s] = FWD_RF;
    end

    always_comb begin
      if (sel[s] == FWD_MEM)
        assert_mem_sel_valid_R1: assert (mem_wen && src[s] != '0 && mem_dst == src[s]);
      if (sel[s] == FWD_WB)
        assert_wb_sel_valid_R2: assert (wb_wen && wb_dst == src[s] &&
                                        !(mem_wen && mem_dst == src[s]));
      if (src[s] == '0)
        assert_zero_no_fwd_R4: assert (sel[s] == FWD_RF);
    end
  end
endmodule

// File: rtl/hzd_id_check.sv
// Decode-stage dependency checks: load-use interlock, branch
// operand readiness, and comparator bypass.
// Producer 0 = execute, producer 1 = memory.
module hzd_id_check #(
  parameter int REG_W = 5,
  parameter int NSRC  = 2
) (
  input  logic [NSRC-1:0][REG_W-1:0] src,
  input  logic [REG_W-1:0]           ex_dst,
  input  logic                       ex_wen,
  input  logic                       ex_load,
  input  logic [REG_W-1:0]           mem_dst,
  input  logic                       mem_wen,
  input  logic                       mem_load,
  input  logic                       branch,
  output logic                       load_use,
  output logic                       br_wait,
  output logic [NSRC-1:0]            cmp_fwd
);
  localparam int NPROD = 2;

  logic [NPROD-1:0][REG_W-1:0] pdst;
  logic [NPROD-1:0]            pwen;
  logic [NSRC-1:0]             lu_s;
  logic [NSRC-1:0]             bw_s;

  assign pdst = {mem_dst, ex_dst};
  assign pwen = {mem_wen, ex_wen};

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    logic [NPROD-1:0] hit;

    hzd_src_match #(.REG_W(REG_W), .NPROD(NPROD)) u_match (
      .src(src[s]), .dst(pdst), .wen(pwen), .hit(hit)
    );

    assign lu_s[s]    = hit[0] && ex_load;
    assign bw_s[s]    = branch && (hit[0] || (hit[1] && mem_load));
    assign cmp_fwd[s] = hit[1] && !mem_load && !hit[0];

    always_comb begin
      if (cmp_fwd[s])
        assert_cmp_fwd_alu_R8: assert (mem_wen && !mem_load && mem_dst == src[s]);
    end
  end

  assign load_use = |lu_s;
  assign br_wait  = |bw_s;
endmodule

// File: rtl/hazard_unit.sv
// Forwarding and interlock control for a five-stage in-order pipeline.
module hazard_unit #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] id_src_a,
  input  logic [REG_W-1:0] id_src_b,
  input  logic [REG_W-1:0] ex_src_a,
  input  logic [REG_W-1:0] ex_src_b,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             ex_wen,
  input  logic             ex_load,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wen,
  input  logic             mem_load,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_wen,
  input  logic             id_branch,
  input  logic             id_br_taken,
  output logic [1:0]       ex_fwd_a,
  output logic [1:0]       ex_fwd_b,
  output logic             id_fwd_a,
  output logic             id_fwd_b,
  output logic             stall,
  output logic             bubble,
  output logic             flush
);
  localparam int NSRC = 2;

  logic [NSRC-1:0][1:0] alu_sel;
  logic [NSRC-1:0]      cmp_fwd;
  logic                 load_use;
  logic                 br_wait;

  hzd_alu_bypass #(.REG_W(REG_W), .NSRC(NSRC)) u_alu (
    .src     ({ex_src_b, ex_src_a}),
    .mem_dst (mem_dst),
    .mem_wen (mem_wen),
    .wb_dst  (wb_dst),
    .wb_wen  (wb_wen),
    .sel     (alu_sel)
  );

  hzd_id_check #(.REG_W(REG_W), .NSRC(NSRC)) u_id (
    .src      ({id_src_b, id_src_a}),
    .ex_dst   (ex_dst),
    .ex_wen   (ex_wen),
    .ex_load  (ex_load),
    .mem_dst  (mem_dst),
    .mem_wen  (mem_wen),
    .mem_load (mem_load),
    .branch   (id_branch),
    .load_use (load_use),
    .br_wait  (br_wait),
    .cmp_fwd  (cmp_fwd)
  );

  assign ex_fwd_a = alu_sel[0];
  assign ex_fwd_b = alu_sel[1];
  assign id_fwd_a = cmp_fwd[0];
  assign id_fwd_b = cmp_fwd[1];
  assign stall    = load_use || br_wait;
  assign bubble   = stall;
  assign flush    = id_branch && id_br_taken && !stall;

  always_comb begin
    if (ex_load && ex_wen && ex_dst != '0 &&
        (ex_dst == id_src_a || ex_dst == id_src_b))
      assert_load_use_stall_R5: assert (stall && bubble);
    if (flush)
      assert_flush_after_ready_R9: assert (!stall && id_branch);
    if (id_branch && mem_load && mem_wen && mem_dst != '0 && mem_dst == id_src_a)
      assert_branch_load_wait_R7: assert (stall && !id_fwd_a);
  end
endmodule

// File: tb/sim_hazard_unit.sv
module sim_hazard_unit;
  localparam int REG_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;   // 125 MHz

  logic [REG_W-1:0] id_src_a, id_src_b, ex_src_a, ex_src_b;
  logic [REG_W-1:0] ex_dst, mem_dst, wb_dst;
  logic ex_wen, ex_load, mem_wen, mem_load, wb_wen, id_branch, id_br_taken;
  logic [1:0] ex_fwd_a, ex_fwd_b;
  logic id_fwd_a, id_fwd_b, stall, bubble, flush;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  hazard_unit #(.REG_W(REG_W)) u0 (.*);

  // ---------------- reference model ----------------
  function automatic logic [1:0] m_ex_fwd(logic [REG_W-1:0] s);
    if (s != 0 && mem_wen && mem_dst == s) return 2'b01;
    if (s != 0 && wb_wen && wb_dst == s)   return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic m_hit_ex(logic [REG_W-1:0] s);
    return s != 0 && ex_wen && ex_dst == s;
  endfunction

  function automatic logic m_hit_mem(logic [REG_W-1:0] s);
    return s != 0 && mem_wen && mem_dst == s;
  endfunction

  function automatic logic m_id_fwd(logic [REG_W-1:0] s);
    return m_hit_mem(s) && !mem_load && !m_hit_ex(s);
  endfunction

  function automatic logic m_stall();
    logic lu, bw;
    lu = ex_load && (m_hit_ex(id_src_a) || m_hit_ex(id_src_b));
    bw = id_branch && (m_hit_ex(id_src_a) || m_hit_ex(id_src_b) ||
                       (mem_load && (m_hit_mem(id_src_a) || m_hit_mem(id_src_b))));
    return lu || bw;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear();
    {id_src_a, id_src_b, ex_src_a, ex_src_b, ex_dst, mem_dst, wb_dst} = '0;
    {ex_wen, ex_load, mem_wen, mem_load, wb_wen, id_branch, id_br_taken} = '0;
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic check_all(string tag);
    logic st;
    st = m_stall();
    chk({tag, " ex_fwd_a"}, ex_fwd_a, m_ex_fwd(ex_src_a));
    chk({tag, " ex_fwd_b"}, ex_fwd_b, m_ex_fwd(ex_src_b));
    chk({tag, " id_fwd_a"}, id_fwd_a, m_id_fwd(id_src_a));
    chk({tag, " id_fwd_b"}, id_fwd_b, m_id_fwd(id_src_b));
    chk({tag, " stall"}, stall, st);
    chk({tag, " bubble"}, bubble, st);
    chk({tag, " flush"}, flush, id_branch && id_br_taken && !st);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    clear();
    repeat (2) @(posedge clk);
    rst = 1'b0;

    // Reset / idle state: nothing in flight
    settle();
    chk("R4 idle ex_fwd_a", ex_fwd_a, 0);
    chk("R4 idle stall", stall, 0);
    chk("R9 idle flush", flush, 0);

    // R1: memory-stage match
    clear(); ex_src_a = 5'd3; mem_dst = 5'd3; mem_wen = 1; settle();
    chk("R1 ex_fwd_a mem", ex_fwd_a, 2'b01);
    chk("R1 ex_fwd_b none", ex_fwd_b, 2'b00);

    // R2: writeback-only match on B
    clear(); ex_src_b = 5'd7; wb_dst = 5'd7; wb_wen = 1; settle();
    chk("R2 ex_fwd_b wb", ex_fwd_b, 2'b10);
    chk("R2 ex_fwd_a rf", ex_fwd_a, 2'b00);

    // R3: both match, younger wins
    clear(); ex_src_a = 5'd9; mem_dst = 5'd9; mem_wen = 1; wb_dst = 5'd9; wb_wen = 1; settle();
    chk("R3 priority", ex_fwd_a, 2'b01);

    // R4: register 0 and write enable low
    clear(); ex_src_a = 0; mem_dst = 0; mem_wen = 1; wb_dst = 0; wb_wen = 1; settle();
    chk("R4 zero no fwd", ex_fwd_a, 2'b00);
    clear(); id_src_a = 0; ex_dst = 0; ex_wen = 1; ex_load = 1; settle();
    chk("R4 zero no stall", stall, 0);
    clear(); ex_src_a = 5'd4; mem_dst = 5'd4; mem_wen = 0; settle();
    chk("R4 wen low no fwd", ex_fwd_a, 2'b00);

    // R5: load-use on source B
    clear(); id_src_b = 5'd6; ex_dst = 5'd6; ex_wen = 1; ex_load = 1; settle();
    chk("R5 load-use stall", stall, 1);
    chk("R5 load-use bubble", bubble, 1);

    // R6: load without dependency; ALU producer with dependency
    clear(); id_src_a = 5'd1; id_src_b = 5'd2; ex_dst = 5'd5; ex_wen = 1; ex_load = 1; settle();
    chk("R6 load no dep", stall, 0);
    clear(); id_src_a = 5'd5; ex_dst = 5'd5; ex_wen = 1; settle();
    chk("R6 alu dep no stall", stall, 0);

    // R7: branch waits on execute ALU result and on memory-stage load
    clear(); id_branch = 1; id_br_taken = 1; id_src_a = 5'd8; ex_dst = 5'd8; ex_wen = 1; settle();
    chk("R7 br on ex alu stall", stall, 1);
    chk("R9 no flush while stalled", flush, 0);
    clear(); id_branch = 1; id_src_b = 5'd8; mem_dst = 5'd8; mem_wen = 1; mem_load = 1; settle();
    chk("R7 br on mem load stall", stall, 1);
    chk("R7 no cmp fwd from load", id_fwd_b, 0);

    // R8: comparator bypass from memory-stage ALU result
    clear(); id_branch = 1; id_src_a = 5'd11; mem_dst = 5'd11; mem_wen = 1; settle();
    chk("R8 cmp fwd a", id_fwd_a, 1);
    chk("R8 no stall", stall, 0);

    // R9: taken branch with ready operands flushes
    id_br_taken = 1; settle();
    chk("R9 flush taken", flush, 1);
    id_br_taken = 0; settle();
    chk("R9 no flush not taken", flush, 0);

    // R10: writeback-only match needs no comparator bypass
    clear(); id_branch = 1; id_src_a = 5'd12; wb_dst = 5'd12; wb_wen = 1; settle();
    chk("R10 cmp no fwd", id_fwd_a, 0);
    chk("R10 no stall", stall, 0);

    // Random vectors over a narrow register range
    for (int i = 0; i < 3000; i++) begin
      id_src_a = REG_W'($urandom_range(0, 3));
      id_src_b = REG_W'($urandom_range(0, 3));
      ex_src_a = REG_W'($urandom_range(0, 3));
      ex_src_b = REG_W'($urandom_range(0, 3));
      ex_dst   = REG_W'($urandom_range(0, 3));
      mem_dst  = REG_W'($urandom_range(0, 3));
      wb_dst   = REG_W'($urandom_range(0, 3));
      ex_wen   = 1'($urandom);
      ex_load  = ex_wen & 1'($urandom);
      mem_wen  = 1'($urandom);
      mem_load = mem_wen & 1'($urandom);
      wb_wen   = 1'($urandom);
      id_branch   = 1'($urandom);
      id_br_taken = 1'($urandom);
      settle();
      check_all("RND");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule